// File: doc/BRIEF.md
# Indexed SMBus Configuration Register Slave

This block is a target on a two-wire SMBus segment. It sees SCL and SDA as plain logic levels and pulls SDA low through a single drive-enable output, so the open-drain pad sits outside it. A fast system clock oversamples both lines. Each line passes through a two-flop synchroniser and a short run-length filter. The block then decodes START, STOP, the address byte and data bits from the filtered levels.

The block answers on a 7-bit address. That address is a base value plus a 3-bit strap value, which gives the 8-bit write addresses D0h, D2h, up to DEh. Every transfer is indexed. To write, the master sends a start offset, then a byte count, then that many data bytes; the bytes land in consecutive registers. To read, the master sends the offset with a write address, issues a repeated START and then a read address. The slave first returns the byte count held in register 7, then data from the offset upward, until the master answers a byte with NACK. A single-byte read is the same sequence with the master stopping after one data byte.

The register bank holds nine bytes:
- four read/write configuration bytes;
- a byte with five writable enable bits;
- two bytes of live pin readback;
- two identification constants.

Two strap pins are captured while reset is held. After that they read back as the captured values, not the current pin levels. The writable bytes are also driven onto parallel output ports.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal ADDR_BASE (68h) plus `addr_strap_i`. It NACKs any other address and leaves SDA released until the next START.
- R2: A write transfer (address with bit 0 = 0, offset byte, count byte N, then N data bytes) stores the data bytes into registers offset, offset+1, and so on, and ACKs every byte.
- R3: A count byte of 00h in a write transfer is NACKed, and no register changes.
- R4: Data bytes beyond the count N are NACKed and not stored.
- R5: After a repeated START with a read address (bit 0 = 1), the slave first sends the value of register 7. It then sends register offset, offset+1, and so on, one per master ACK.
- R6: A master NACK ends the read; the slave releases SDA, and a following STOP leaves it ready for a new transfer. A single-byte read returns the register at the offset.
- R7: After reset, register 0 = 00h, registers 1 and 2 = FFh, register 7 = 09h, and register 8 bits [4:0] = 1Fh; SDA is released.
- R8: Writes to registers 3, 4, 5 and 6, and to bits [7:5] of register 8, have no effect. The read-only contents are:
  - register 3 = {pin[6:0], bypass strap latched in reset};
  - register 4 = pin[14:7], live;
  - register 5 = REV_ID;
  - register 6 = DEV_ID;
  - register 8 bit 7 = frequency strap latched in reset, bits [6:5] = 0.
- R9: Writes to offsets 9 and above are ACKed but change nothing; reads from them return 00h.
- R10: A START or STOP at any bit position abandons the current transfer without storing a partial byte. A START always begins a new address phase.
- R11: The output ports `gear_cfg_o`, `oe_lo_o`, `oe_mid_o`, `blk_cnt_o` and `oe_hi_o` carry registers 0, 1, 2, 7 and 8[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High to pull SDA low |
| addr_strap_i | input | 3 | Address strap added to the base address |
| oe_pin_n_i | input | 15 | Output-enable pin levels for readback |
| strap_byp_i | input | 1 | Bypass strap, captured in reset |
| strap_fs_i | input | 1 | Frequency-range strap, captured in reset |
| gear_cfg_o | output | 8 | Register 0 |
| oe_lo_o | output | 8 | Register 1 |
| oe_mid_o | output | 8 | Register 2 |
| blk_cnt_o | output | 8 | Register 7, the count returned by reads |
| oe_hi_o | output | 5 | Register 8 bits [4:0] |

## Verification
The bench builds the block with its default parameters: a filter length of 3, ADDR_BASE 68h, REV_ID 31h, DEV_ID 45h and a count reset value of 09h. It straps the address to 3'b101, so an error in how the strap is added to the base address changes which address gets an ACK. The SCL period of 32 system clocks leaves about half a low phase between the filtered SCL edge and the next master edge, so a slave that drives or samples one stage late shows up as a corrupted bit. The readback pin pattern differs bit by bit, and the straps are flipped after reset, so a swapped field or a live-instead-of-latched strap gives a wrong readback value.

// File: rtl/smb_cfg_pkg.sv
// Shared constants and types for the indexed SMBus register slave.
package smb_cfg_pkg;
    localparam int NREG   = 9;          // implemented register count
    localparam int IDX_W  = 8;          // width of offset / pointer
    localparam int LIVE_W = 15;         // live pin readback width
    localparam int CNT_IDX = 7;         // register supplying the read count

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_RX, ST_ACK_RX, ST_TX, ST_ACK_TX
    } smb_state_e;

    typedef enum logic [1:0] {
        K_OFFSET, K_COUNT, K_DATA
    } rx_kind_e;
endpackage

// File: rtl/smb_glitch_filter.sv
// Synchronises one bus line into the clk domain and removes pulses shorter
// than FILT_LEN clocks. Output only changes after FILT_LEN equal samples.
// Assumes the line idles high; reset value is 1.
module smb_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Two-flop synchroniser followed by a sample history and level decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            hist_q  <= '1;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                clean_o <= 1'b1;
            else if (~|hist_q)
                clean_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smb_cfg_bank.sv
// Nine-byte register bank: RW configuration bytes, live pin readback,
// straps latched during reset and constant identification bytes.
// Writes to read-only bits or to offsets >= NREG are dropped; reads there give 0.
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter logic [7:0] REV_ID  = 8'h31,
    parameter logic [7:0] DEV_ID  = 8'h45,
    parameter logic [7:0] CNT_RST = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    input  logic [LIVE_W-1:0] live_i,
    input  logic              strap_byp_i,
    input  logic              strap_fs_i,
    output logic [7:0]        r0_o,
    output logic [7:0]        r1_o,
    output logic [7:0]        r2_o,
    output logic [7:0]        r7_o,
    output logic [4:0]        r8_o
);
    logic [LIVE_W-1:0] live_q;
    logic              byp_lat, fs_lat;

    // Capture straps while reset is held, keep them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_lat <= strap_byp_i;
            fs_lat  <= strap_fs_i;
        end
    end

    // Register the live pin levels once for readback.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_i;
    end

    // Writable storage with per-offset decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_o <= 8'h00;
            r1_o <= 8'hFF;
            r2_o <= 8'hFF;
            r7_o <= CNT_RST;
            r8_o <= 5'h1F;
        end else if (wr_en) begin
            case (wr_idx)
                8'd0:    r0_o <= wr_data;
                8'd1:    r1_o <= wr_data;
                8'd2:    r2_o <= wr_data;
                8'd7:    r7_o <= wr_data;
                8'd8:    r8_o <= wr_data[4:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_idx)
            8'd0:    rd_data = r0_o;
            8'd1:    rd_data = r1_o;
            8'd2:    rd_data = r2_o;
            8'd3:    rd_data = {live_q[6:0], byp_lat};
            8'd4:    rd_data = live_q[14:7];
            8'd5:    rd_data = REV_ID;
            8'd6:    rd_data = DEV_ID;
            8'd7:    rd_data = r7_o;
            8'd8:    rd_data = {fs_lat, 2'b00, r8_o};
            default: rd_data = 8'h00;
        endcase
    end

    p_oob_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NREG)) |=> $stable({r0_o, r1_o, r2_o, r7_o, r8_o}));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'd1) |=> (r1_o == $past(wr_data)));

    p_strap_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable({byp_lat, fs_lat}));
endmodule

// File: rtl/smb_proto_fsm.sv
// Bit-level SMBus target engine working on filtered SCL/SDA. Samples data on
// SCL rise, changes its SDA drive after SCL fall. Handles address match,
// offset/count/data reception and count-then-data transmission.
// Assumes SCL low and high phases each last well beyond the filter latency.
module smb_proto_fsm
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [2:0]       addr_strap,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    smb_state_e       state;
    rx_kind_e         kind;
    logic             scl_q, sda_q, rw, mack;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg, tx_sh, remaining;
    logic [IDX_W-1:0] ptr;
    logic [6:0]       my_addr;

    assign my_addr = ADDR_BASE + {4'b0, addr_strap};

    logic start_det, stop_det, scl_rise, scl_fall;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;

    // Previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Count is fetched while acknowledging the read address, data otherwise.
    assign rd_idx = (state == ST_ACK_ADDR) ? IDX_W'(CNT_IDX) : ptr;

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  kind <= K_OFFSET;
            rw <= 1'b0;  mack <= 1'b0;  bitcnt <= '0;
            shreg <= '0;  tx_sh <= '0;  remaining <= '0;  ptr <= '0;
            wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;  sda_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state <= ST_ADDR;  bitcnt <= '0;  sda_oe <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;  sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == my_addr) begin
                                    rw <= shreg[0];  sda_oe <= 1'b1;  state <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                case (kind)
                                    K_OFFSET: begin
                                        ptr <= shreg;  kind <= K_COUNT;
                                        sda_oe <= 1'b1;  state <= ST_ACK_RX;
                                    end
                                    K_COUNT: begin
                                        if (shreg == 8'h00) state <= ST_IDLE;
                                        else begin
                                            remaining <= shreg;  kind <= K_DATA;
                                            sda_oe <= 1'b1;  state <= ST_ACK_RX;
                                        end
                                    end
                                    default: begin
                                        if (remaining == 8'h00) state <= ST_IDLE;
                                        else begin
                                            wr_en <= 1'b1;  wr_idx <= ptr;  wr_data <= shreg;
                                            ptr <= ptr + 1'b1;  remaining <= remaining - 8'd1;
                                            sda_oe <= 1'b1;  state <= ST_ACK_RX;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                tx_sh <= rd_data;  sda_oe <= ~rd_data[7];  state <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;  kind <= K_OFFSET;  state <= ST_RX;
                            end
                        end
                    end
                    ST_ACK_RX: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;  state <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bitcnt <= bitcnt + 4'd1;
                        else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;  bitcnt <= '0;  state <= ST_ACK_TX;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_ACK_TX: begin
                        if (scl_rise) mack <= ~sda_f;
                        else if (scl_fall) begin
                            if (mack) begin
                                tx_sh <= rd_data;  sda_oe <= ~rd_data[7];
                                ptr <= ptr + 1'b1;  state <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    p_ack_only_own_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_ADDR) |-> (shreg[7:1] == my_addr));

    p_drive_states_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK_ADDR || state == ST_ACK_RX || state == ST_TX));

    p_write_within_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(remaining) != 8'h00));
endmodule

// File: rtl/smb_cfg_slave.sv
// Top of the indexed SMBus configuration slave: two line filters, the protocol
// engine and the register bank. SDA is pulled low when sda_oe_o is high.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         FILT_LEN  = 3,
    parameter logic [6:0] ADDR_BASE = 7'h68,
    parameter logic [7:0] REV_ID    = 8'h31,
    parameter logic [7:0] DEV_ID    = 8'h45,
    parameter logic [7:0] CNT_RST   = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        addr_strap_i,
    input  logic [LIVE_W-1:0] oe_pin_n_i,
    input  logic              strap_byp_i,
    input  logic              strap_fs_i,
    output logic [7:0]        gear_cfg_o,
    output logic [7:0]        oe_lo_o,
    output logic [7:0]        oe_mid_o,
    output logic [7:0]        blk_cnt_o,
    output logic [4:0]        oe_hi_o
);
    logic [1:0]       raw_lines, clean_lines;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g])
        );
    end

    smb_proto_fsm #(.ADDR_BASE(ADDR_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_f(clean_lines[0]), .sda_f(clean_lines[1]),
        .addr_strap(addr_strap_i), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o)
    );

    smb_cfg_bank #(.REV_ID(REV_ID), .DEV_ID(DEV_ID), .CNT_RST(CNT_RST)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .live_i(oe_pin_n_i), .strap_byp_i(strap_byp_i), .strap_fs_i(strap_fs_i),
        .r0_o(gear_cfg_o), .r1_o(oe_lo_o), .r2_o(oe_mid_o), .r7_o(blk_cnt_o), .r8_o(oe_hi_o)
    );

    p_release_in_reset_r7: assert property (@(posedge clk)
        $past(!rst_n) |-> !sda_oe_o);
endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
    localparam int Q = 8;                      // quarter SCL period in clocks
    localparam logic [2:0]  STRAP = 3'b101;
    localparam logic [7:0]  AW = {7'h68 + 7'(STRAP), 1'b0};
    localparam logic [7:0]  AR = AW | 8'h01;
    localparam logic [7:0]  AW_BAD = {7'h68 + 7'(STRAP ^ 3'b001), 1'b0};
    localparam logic [14:0] LIVE0 = 15'h2A5B;
    localparam logic [14:0] LIVE1 = 15'h15C3;
    localparam logic        BYP0 = 1'b0, FS0 = 1'b1;
    localparam logic [7:0]  EXP3 = {LIVE0[6:0], BYP0};
    localparam logic [7:0]  EXP4 = LIVE0[14:7];
    localparam int NV = 11;
    // {offset, written byte, expected readback}
    localparam logic [23:0] VEC [NV] = '{
        {8'd0, 8'hA5, 8'hA5}, {8'd1, 8'h3C, 8'h3C}, {8'd2, 8'h81, 8'h81},
        {8'd8, 8'h00, {FS0, 7'h00}}, {8'd8, 8'h3F, {FS0, 2'b00, 5'h1F}},
        {8'd3, 8'h00, EXP3}, {8'd4, 8'hFF, EXP4}, {8'd5, 8'h00, 8'h31},
        {8'd6, 8'h00, 8'h45}, {8'd9, 8'h77, 8'h00}, {8'hC3, 8'h12, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = STRAP;
    logic [14:0] live = LIVE0;
    logic byp = BYP0, fs = FS0;
    logic sda_oe;
    logic [7:0] gear, oe_lo, oe_mid, bcnt;
    logic [4:0] oe_hi;
    wire sda_line = sda_m & ~sda_oe;
    int n_chk = 0, n_bad = 0;
    logic [7:0] rb [4];
    logic [7:0] rcnt;
    logic a0, a1, a2, a3, a4;

    always #2.5 clk = ~clk;

    smb_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_strap_i(strap), .oe_pin_n_i(live), .strap_byp_i(byp), .strap_fs_i(fs),
        .gear_cfg_o(gear), .oe_lo_o(oe_lo), .oe_mid_o(oe_mid), .blk_cnt_o(bcnt), .oe_hi_o(oe_hi)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(~give_ack, r);
    endtask

    task automatic wr1(input logic [7:0] off, input logic [7:0] d);
        m_start; m_wbyte(AW, a0); m_wbyte(off, a1); m_wbyte(8'h01, a2); m_wbyte(d, a3); m_stop;
    endtask

    // Indexed read of n data bytes; count byte lands in rcnt, data in rb.
    task automatic rdn(input logic [7:0] off, input int n);
        m_start; m_wbyte(AW, a0); m_wbyte(off, a1);
        m_start; m_wbyte(AR, a2);
        m_rbyte(1'b1, rcnt);
        for (int k = 0; k < n; k++) m_rbyte(k < n - 1, rb[k]);
        m_stop;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(4);
        byp = ~BYP0; fs = ~FS0;          // straps move after reset: latched values must stay
        // R7 reset state
        chk("R7 reg0", gear, 8'h00);
        chk("R7 reg1", oe_lo, 8'hFF);
        chk("R7 reg2", oe_mid, 8'hFF);
        chk("R7 reg7", bcnt, 8'h09);
        chk("R7 reg8", {3'b0, oe_hi}, 8'h1F);
        chk("R7 sda released", {7'b0, sda_oe}, 8'h00);
        tick(4*Q);

        // Table walk: single-byte write then single-byte read back
        for (int v = 0; v < NV; v++) begin
            logic [7:0] off, wd, ex;
            string tg;
            {off, wd, ex} = VEC[v];
            tg = (off > 8'd8) ? "R9" : ((off >= 8'd3 && off <= 8'd6) || off == 8'd8) ? "R8" : "R2";
            wr1(off, wd);
            chk({tg, " write acks"}, {4'b0, a0, a1, a2, a3}, 8'h0F);
            rdn(off, 1);
            chk("R5 count byte", rcnt, 8'h09);
            chk({tg, " readback"}, rb[0], ex);
        end

        // R2 R11 multi-byte write lands on ports
        m_start; m_wbyte(AW, a0); m_wbyte(8'h00, a1); m_wbyte(8'h03, a2);
        m_wbyte(8'h11, a3); m_wbyte(8'h22, a4); m_wbyte(8'h33, a4); m_stop;
        chk("R2 burst acks", {4'b0, a0, a1, a2, a3}, 8'h0F);
        chk("R11 gear port", gear, 8'h11);
        chk("R11 oe_lo port", oe_lo, 8'h22);
        chk("R11 oe_mid port", oe_mid, 8'h33);

        // R4 byte beyond count is NACKed and dropped
        m_start; m_wbyte(AW, a0); m_wbyte(8'h01, a1); m_wbyte(8'h01, a2);
        m_wbyte(8'h44, a3); m_wbyte(8'h55, a4); m_stop;
        chk("R4 in-count ack", {7'b0, a3}, 8'h01);
        chk("R4 excess nack", {7'b0, a4}, 8'h00);
        chk("R4 reg1", oe_lo, 8'h44);
        chk("R4 reg2 untouched", oe_mid, 8'h33);

        // R3 zero count
        m_start; m_wbyte(AW, a0); m_wbyte(8'h00, a1); m_wbyte(8'h00, a2); m_wbyte(8'h99, a3); m_stop;
        chk("R3 zero count nack", {6'b0, a2, a3}, 8'h00);
        chk("R3 reg0 untouched", gear, 8'h11);

        // R1 foreign address
        m_start; m_wbyte(AW_BAD, a0); m_wbyte(8'h00, a1); m_wbyte(8'h01, a2); m_wbyte(8'h77, a3); m_stop;
        chk("R1 foreign nack", {4'b0, a0, a1, a2, a3}, 8'h00);
        chk("R1 reg0 untouched", gear, 8'h11);

        // R6 early end by NACK, then single-byte read
        rdn(8'h00, 2);
        chk("R6 first byte", rb[0], 8'h11);
        chk("R6 second byte", rb[1], 8'h44);
        rdn(8'h02, 1);
        chk("R6 single read", rb[0], 8'h33);

        // R9 read running past the last register
        rdn(8'h08, 2);
        chk("R9 reg8", rb[0], {FS0, 2'b00, 5'h1F});
        chk("R9 past end", rb[1], 8'h00);

        // R10 stop in mid-byte
        m_start; m_wbyte(AW, a0); m_wbyte(8'h00, a1); m_wbyte(8'h02, a2);
        m_bit(1'b1, a3); m_bit(1'b0, a3); m_bit(1'b1, a3); m_bit(1'b0, a3);
        m_stop;
        chk("R10 stop abandons", gear, 8'h11);
        chk("R10 sda released", {7'b0, sda_oe}, 8'h00);
        // R10 repeated start in mid-byte, then a new write
        m_start; m_wbyte(AW, a0); m_wbyte(8'h01, a1); m_wbyte(8'h01, a2);
        m_bit(1'b0, a3); m_bit(1'b1, a3); m_bit(1'b0, a3);
        m_start; m_wbyte(AW, a0); m_wbyte(8'h01, a1); m_wbyte(8'h01, a2); m_wbyte(8'h66, a3); m_stop;
        chk("R10 restart acks", {4'b0, a0, a1, a2, a3}, 8'h0F);
        chk("R10 restart write", oe_lo, 8'h66);

        // R5 count byte follows register 7
        wr1(8'h07, 8'h03);
        chk("R5 reg7 port", bcnt, 8'h03);
        rdn(8'h00, 1);
        chk("R5 new count", rcnt, 8'h03);
        chk("R5 data at offset", rb[0], 8'h11);

        // R8 live pins follow the inputs
        live = LIVE1;
        tick(4);
        rdn(8'h04, 1);
        chk("R8 live pins", rb[0], LIVE1[14:7]);
        rdn(8'h03, 1);
        chk("R8 latched bypass", rb[0], {LIVE1[6:0], BYP0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule